// File: doc/BRIEF.md
# Compare, Branch and Loop-Index Unit

This block is the control-flow slice of an accumulator machine whose words are 24-bit two's-complement values. It keeps a persistent condition code, written by compare operations and by the counted-loop step. Later conditional jumps read that code to choose between the jump target and the sequential program counter. Subroutine calls save their return address in a dedicated link register, and returns jump back through it.

Each cycle the surrounding datapath presents one operation code together with the accumulator, a memory operand, a register operand, the jump target and the sequential PC. The block returns the next PC within the same cycle. The condition code, index register X and link register L change at the following rising clock edge. Instruction fetch and arithmetic are handled elsewhere.

Top module: `flow_ctl_unit`

## Requirements
- R1: A synchronous active-low reset sets the condition code to equal (01), X to zero and L to zero.
- R2: Operation code 1 (compare) compares the accumulator with the memory operand as signed 24-bit numbers. At the next edge it writes the condition code: less=00, equal=01, greater=10, with the accumulator on the left.
- R3: Operation codes 2, 3 and 4 (jump if less, equal or greater) drive next_pc to the target in the same cycle when the stored condition code is 00, 01 or 10 respectively. Otherwise next_pc is the sequential PC.
- R4: Operation code 5 (call) drives next_pc to the target in the same cycle. At the next edge it loads L with the sequential PC, zero-extended to 24 bits.
- R5: Operation code 6 (return) drives next_pc to the low address bits of L in the same cycle.
- R6: Operation code 7 (loop step, memory form) adds 1 to X, wrapping modulo 2^24. At the same edge it sets the condition code from a signed comparison of the incremented X against the memory operand.
- R7: Operation code 8 (loop step, register form) behaves like R6, but compares against the register operand.
- R8: The condition code keeps its value through every operation other than codes 1, 7 and 8. X changes only on codes 7 and 8, and L changes only on code 5.
- R9: Code 0 and the unused codes 9 to 15 change no state and select the sequential PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Operation selector |
| acc_a | input | 24 | Accumulator value |
| mem_opnd | input | 24 | Memory word operand |
| reg_opnd | input | 24 | Named register operand for the register-form loop step |
| target_addr | input | 15 | Jump or call target address |
| seq_pc | input | 15 | Sequential (return) PC |
| next_pc | output | 15 | Selected next PC, combinational |
| x_out | output | 24 | Index register X |
| l_out | output | 24 | Link register L |
| cc_out | output | 2 | Condition code |

## Verification
next_pc is combinational, so the bench checks it in the same cycle as the operation that drives it, against the condition code and L as they stood before that cycle's edge. The condition code, X and L are registered one edge after the operation. The bench drives each operation just after a falling edge and samples all outputs 2 ns later. At that point the registered outputs show the effect of the operation from the previous cycle. A behavioural model steps through the same ordering and is compared on every clock, over directed call, compare and loop sequences and a stretch of mixed operation codes.

// File: rtl/flow_ctl_pkg.sv
// Shared types for the control-flow unit: operation codes and condition-code values.
// Assumes 4-bit operation codes; unused values are treated as no-ops by the decoder.
package flow_ctl_pkg;

    typedef enum logic [1:0] {
        CC_LT = 2'b00,
        CC_EQ = 2'b01,
        CC_GT = 2'b10
    } cc_t;

    localparam logic [3:0] OPC_NOP  = 4'd0;
    localparam logic [3:0] OPC_CMP  = 4'd1;
    localparam logic [3:0] OPC_JLT  = 4'd2;
    localparam logic [3:0] OPC_JEQ  = 4'd3;
    localparam logic [3:0] OPC_JGT  = 4'd4;
    localparam logic [3:0] OPC_CALL = 4'd5;
    localparam logic [3:0] OPC_RET  = 4'd6;
    localparam logic [3:0] OPC_STPM = 4'd7;
    localparam logic [3:0] OPC_STPR = 4'd8;

    typedef enum logic [1:0] {
        PC_SEQ  = 2'd0,
        PC_TGT  = 2'd1,
        PC_LINK = 2'd2,
        PC_COND = 2'd3
    } pc_src_t;

    typedef struct packed {
        logic    cc_write;   // condition code is rewritten this cycle
        logic    use_step;   // compare X+1 instead of the accumulator
        logic    step_reg;   // loop step takes the register operand
        logic    link_write; // L takes the sequential PC
        pc_src_t pc_src;     // next-PC source
        cc_t     want_cc;    // condition a conditional jump requires
    } ctl_t;

endpackage

// File: rtl/flow_ctl_decode.sv
// Decodes the operation code into control fields.
// Assumes codes outside the defined set behave as a no-op.
module flow_ctl_decode
    import flow_ctl_pkg::*;
(
    input  logic [3:0] op_code,
    output ctl_t       ctl
);

    // Map each operation code onto its control fields.
    always_comb begin
        ctl            = '0;
        ctl.pc_src     = PC_SEQ;
        ctl.want_cc    = CC_EQ;
        case (op_code)
            OPC_CMP:  ctl.cc_write = 1'b1;
            OPC_JLT:  begin ctl.pc_src = PC_COND; ctl.want_cc = CC_LT; end
            OPC_JEQ:  begin ctl.pc_src = PC_COND; ctl.want_cc = CC_EQ; end
            OPC_JGT:  begin ctl.pc_src = PC_COND; ctl.want_cc = CC_GT; end
            OPC_CALL: begin ctl.pc_src = PC_TGT; ctl.link_write = 1'b1; end
            OPC_RET:  ctl.pc_src = PC_LINK;
            OPC_STPM: begin ctl.cc_write = 1'b1; ctl.use_step = 1'b1; end
            OPC_STPR: begin
                ctl.cc_write = 1'b1;
                ctl.use_step = 1'b1;
                ctl.step_reg = 1'b1;
            end
            default:  ctl = ctl;
        endcase
    end

endmodule

// File: rtl/flow_ctl_cmp.sv
// Signed magnitude comparison of two W-bit two's-complement words.
// Produces a condition code from the left operand's point of view.
module flow_ctl_cmp
    import flow_ctl_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output cc_t          result
);

    // Classify lhs against rhs as less, equal or greater.
    always_comb begin
        if ($signed(lhs) < $signed(rhs))
            result = CC_LT;
        else if (lhs == rhs)
            result = CC_EQ;
        else
            result = CC_GT;
    end

endmodule

// File: rtl/flow_ctl_pcsel.sv
// Chooses the next PC from the sequential PC, the target, or the link address.
// Assumes the stored condition code is the one present before this cycle's edge.
module flow_ctl_pcsel
    import flow_ctl_pkg::*;
#(
    parameter int AW = 15
) (
    input  pc_src_t       pc_src,
    input  cc_t           want_cc,
    input  cc_t           cc_now,
    input  logic [AW-1:0] seq_pc,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] link_addr,
    output logic [AW-1:0] pc_out
);

    // Select the next-PC source; a conditional jump is taken only on a matching code.
    always_comb begin
        case (pc_src)
            PC_TGT:  pc_out = target;
            PC_LINK: pc_out = link_addr;
            PC_COND: pc_out = (cc_now == want_cc) ? target : seq_pc;
            default: pc_out = seq_pc;
        endcase
    end

endmodule

// File: rtl/flow_ctl_unit.sv
// Top of the control-flow unit: holds the condition code, index X and link L.
// Assumes one operation per cycle; next_pc is combinational, state updates at the edge.
module flow_ctl_unit
    import flow_ctl_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_code,
    input  logic [WORD_W-1:0] acc_a,
    input  logic [WORD_W-1:0] mem_opnd,
    input  logic [WORD_W-1:0] reg_opnd,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic [WORD_W-1:0] x_out,
    output logic [WORD_W-1:0] l_out,
    output logic [1:0]        cc_out
);

    localparam int PAD_W = WORD_W - ADDR_W;

    ctl_t              ctl;
    cc_t               cc_q;
    cc_t               cmp_res;
    logic [WORD_W-1:0] x_q;
    logic [WORD_W-1:0] l_q;
    logic [WORD_W-1:0] x_inc;
    logic [WORD_W-1:0] cmp_lhs;
    logic [WORD_W-1:0] cmp_rhs;

    flow_ctl_decode u_dec (
        .op_code (op_code),
        .ctl     (ctl)
    );

    // Incremented index used by both loop-step forms.
    always_comb x_inc = x_q + WORD_W'(1);

    // Pick the compare operands for a plain compare or a loop step.
    always_comb begin
        cmp_lhs = ctl.use_step ? x_inc : acc_a;
        cmp_rhs = ctl.step_reg ? reg_opnd : mem_opnd;
    end

    flow_ctl_cmp #(.W(WORD_W)) u_cmp (
        .lhs    (cmp_lhs),
        .rhs    (cmp_rhs),
        .result (cmp_res)
    );

    flow_ctl_pcsel #(.AW(ADDR_W)) u_pc (
        .pc_src    (ctl.pc_src),
        .want_cc   (ctl.want_cc),
        .cc_now    (cc_q),
        .seq_pc    (seq_pc),
        .target    (target_addr),
        .link_addr (l_q[ADDR_W-1:0]),
        .pc_out    (next_pc)
    );

    // Condition-code register: written only by compare and loop-step operations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_q <= CC_EQ;
        else if (ctl.cc_write)
            cc_q <= cmp_res;
    end

    // Index register: advanced only by the loop-step operations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            x_q <= '0;
        else if (ctl.use_step)
            x_q <= x_inc;
    end

    // Link register: captures the return address on a call.
    always_ff @(posedge clk) begin
        if (!rst_n)
            l_q <= '0;
        else if (ctl.link_write)
            l_q <= {{PAD_W{1'b0}}, seq_pc};
    end

    assign x_out  = x_q;
    assign l_out  = l_q;
    assign cc_out = cc_q;

    // R8
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_code == OPC_CMP || op_code == OPC_STPM || op_code == OPC_STPR) |=> $stable(cc_out));

    // R8
    x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_code == OPC_STPM || op_code == OPC_STPR) |=> $stable(x_out));

    // R6
    x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_STPM || op_code == OPC_STPR) |=> (x_out == $past(x_out) + WORD_W'(1)));

    // R4
    link_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_CALL) |=> (l_out == {{PAD_W{1'b0}}, $past(seq_pc)}));

    // R5
    ret_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_RET) |-> (next_pc == l_out[ADDR_W-1:0]));

    // R2
    cc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_out != 2'b11));

    // R9
    idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_NOP || op_code > OPC_STPR) |-> (next_pc == seq_pc));

endmodule

// File: tb/flow_ctl_unit_test.sv
module flow_ctl_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [23:0] acc_a = '0;
    logic [23:0] mem_opnd = '0;
    logic [23:0] reg_opnd = '0;
    logic [14:0] target_addr = '0;
    logic [14:0] seq_pc = '0;
    logic [14:0] next_pc;
    logic [23:0] x_out;
    logic [23:0] l_out;
    logic [1:0]  cc_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Reference state
    int          m_cc;
    logic [23:0] m_x;
    logic [23:0] m_l;

    always #10 clk = ~clk;

    flow_ctl_unit uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .acc_a(acc_a),
        .mem_opnd(mem_opnd), .reg_opnd(reg_opnd), .target_addr(target_addr),
        .seq_pc(seq_pc), .next_pc(next_pc), .x_out(x_out), .l_out(l_out),
        .cc_out(cc_out)
    );

    function automatic int sgn_cmp(logic [23:0] a, logic [23:0] b);
        if ($signed(a) < $signed(b)) return 0;
        if (a == b) return 1;
        return 2;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one operation, compare all outputs, then advance the model.
    task automatic step(string tag, logic [3:0] op, logic [23:0] a, logic [23:0] m,
                        logic [23:0] r, logic [14:0] tgt, logic [14:0] sq);
        logic [14:0] exp_pc;
        @(negedge clk);
        op_code = op; acc_a = a; mem_opnd = m; reg_opnd = r;
        target_addr = tgt; seq_pc = sq;
        #2;
        exp_pc = sq;
        case (op)
            4'd2: if (m_cc == 0) exp_pc = tgt;
            4'd3: if (m_cc == 1) exp_pc = tgt;
            4'd4: if (m_cc == 2) exp_pc = tgt;
            4'd5: exp_pc = tgt;
            4'd6: exp_pc = m_l[14:0];
            default: exp_pc = sq;
        endcase
        check({tag, " next_pc"}, next_pc, exp_pc);
        check({tag, " cc (R8)"}, cc_out, m_cc);
        check({tag, " x (R8)"}, x_out, m_x);
        check({tag, " l (R8)"}, l_out, m_l);
        case (op)
            4'd1: m_cc = sgn_cmp(a, m);
            4'd5: m_l = {9'd0, sq};
            4'd7: begin m_x = m_x + 24'd1; m_cc = sgn_cmp(m_x, m); end
            4'd8: begin m_x = m_x + 24'd1; m_cc = sgn_cmp(m_x, r); end
            default: ;
        endcase
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cc = 1; m_x = '0; m_l = '0;
        #2;
        check("R1 cc", cc_out, 1);
        check("R1 x", x_out, 0);
        check("R1 l", l_out, 0);

        // R2 / R3: equal then jumps
        step("R2 cmp eq", 4'd1, 24'd5, 24'd5, 0, 15'h10, 15'h1);
        step("R3 jeq taken", 4'd3, 0, 0, 0, 15'h20, 15'h2);
        step("R3 jlt not", 4'd2, 0, 0, 0, 15'h21, 15'h3);
        step("R3 jgt not", 4'd4, 0, 0, 0, 15'h22, 15'h4);
        // R2 signed less: -3 vs 2
        step("R2 cmp lt", 4'd1, 24'hFFFFFD, 24'd2, 0, 15'h0, 15'h5);
        step("R3 jlt taken", 4'd2, 0, 0, 0, 15'h30, 15'h6);
        // R2 signed greater: 7 vs -1
        step("R2 cmp gt", 4'd1, 24'd7, 24'hFFFFFF, 0, 15'h0, 15'h7);
        step("R3 jgt taken", 4'd4, 0, 0, 0, 15'h31, 15'h8);
        // R9: idle and unused codes hold everything
        step("R9 nop", 4'd0, 24'd1, 24'd9, 24'd9, 15'h77, 15'h9);
        step("R9 code12", 4'd12, 24'd1, 24'd9, 24'd9, 15'h77, 15'hA);
        step("R9 code15", 4'd15, 24'd1, 24'd9, 24'd9, 15'h77, 15'hB);
        step("R8 jgt after idle", 4'd4, 0, 0, 0, 15'h32, 15'hC);
        // R4 / R5: call then return
        step("R4 call", 4'd5, 0, 0, 0, 15'h1234, 15'h0100);
        step("R5 ret", 4'd6, 0, 0, 0, 15'h7FFF, 15'h1235);
        step("R4 call max", 4'd5, 0, 0, 0, 15'h0042, 15'h7FFF);
        step("R5 ret max", 4'd6, 0, 0, 0, 15'h0, 15'h43);
        // R7: register-form loop to 3
        for (int i = 0; i < 3; i++) begin
            step("R7 step reg", 4'd8, 0, 24'd100, 24'd3, 15'h0, 15'h50);
            step("R7 loop jlt", 4'd2, 0, 0, 0, 15'h40, 15'h51);
        end
        // R6: memory form, incl. negative operand
        step("R6 step mem", 4'd7, 0, 24'd4, 24'd0, 15'h0, 15'h60);
        step("R6 step mem gt", 4'd7, 0, 24'd2, 24'd0, 15'h0, 15'h61);
        step("R6 step mem neg", 4'd7, 0, 24'hFFFFFF, 24'd0, 15'h0, 15'h62);
        step("R6 check cc", 4'd3, 0, 0, 0, 15'h63, 15'h64);
        // Mixed stretch
        for (int i = 0; i < 300; i++) begin
            logic [3:0]  op;
            logic [23:0] va, vm, vr;
            op = 4'($urandom_range(0, 15));
            va = 24'($urandom_range(0, 15)) - 24'd8;
            vm = 24'($urandom_range(0, 15)) - 24'd8;
            vr = 24'($urandom_range(0, 40));
            step("R8 mixed", op, va, vm, vr, 15'($urandom), 15'($urandom));
        end
        // Reset again mid-run
        @(negedge clk);
        rst_n = 1'b0; op_code = 4'd7;
        @(negedge clk);
        rst_n = 1'b1; op_code = 4'd0;
        m_cc = 1; m_x = '0; m_l = '0;
        #2;
        check("R1 cc again", cc_out, 1);
        check("R1 x again", x_out, 0);
        check("R1 l again", l_out, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule